// File: doc/BRIEF.md
# Compare-and-Jump Condition Unit

This block decides whether a compare-and-jump instruction branches and produces the instruction pointer that follows it. Each accepted request carries a 3-bit condition code, a first operand taken from a source register, a second register operand, a 16-bit immediate field, a form select, the current instruction pointer and the jump target. In the register form the two register operands are compared. In the immediate form the first operand is compared with the sign-extended immediate.

The result is registered. One clock after a request is accepted, the block presents a taken flag, an illegal-condition flag and the next instruction pointer. That pointer is the jump target when the branch is taken and the current pointer plus one when it is not. The "less than" comparisons have no code of their own. Software obtains them by swapping the operands of the "greater" codes.

Top module: `cj_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request, out_valid, taken and illegal are 0 and next_ip is 0.
- R2: A request with in_valid=1 at a rising clock edge produces out_valid=1 exactly one cycle later. In a cycle with no request, out_valid is 0, and taken, illegal and next_ip keep their previous values.
- R3: Condition code 0 (binary 000) is always taken, whatever the operand values.
- R4: Code 1 (001) is taken when the first operand equals the second. Code 2 (010) is taken when they differ.
- R5: Code 3 (011) is taken when the first operand is greater than the second as 32-bit unsigned values. Code 4 (100) is taken when it is greater or equal as unsigned values.
- R6: Code 5 (101) is taken when the first operand is greater than the second as two's-complement signed values. Code 6 (110) is taken when it is greater or equal as signed values.
- R7: Code 7 (111) is reserved. It is never taken and sets illegal=1. For codes 0 to 6, illegal=0.
- R8: With imm_sel=1 the second operand is imm16 sign-extended to 32 bits (bit 15 copied into bits 31:16), and rs2_val has no effect on the result.
- R9: With imm_sel=0 the second operand is rs2_val, and imm16 (including its low 3 bits) has no effect on the result.
- R10: next_ip equals jump_tgt when the branch is taken. Otherwise it equals cur_ip + 1, modulo 2^32, so 32'hFFFFFFFF is followed by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| cond | input | 3 | Condition code |
| imm_sel | input | 1 | 1 = immediate form, 0 = register form |
| rs1_val | input | 32 | First operand |
| rs2_val | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| cur_ip | input | 32 | Current instruction pointer |
| jump_tgt | input | 32 | Branch target address |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Reserved condition code seen |
| next_ip | output | 32 | Next instruction pointer |

## Verification
A fault in the operand select or the comparators changes the taken flag. Because taken also chooses the pointer, the same fault shows up in next_ip, on the out_valid cycle that follows the offending request, with no further delay. The corner cases are chosen to split the signed and unsigned codes apart: a top-bit-set operand against a small positive one, equal operands under every "greater" and "greater-or-equal" code, and negative immediates whose sign extension decides equality. Register-form requests repeated with different immediate fields, and immediate-form requests repeated with different rs2 values, must give identical results. Wraparound of the sequential pointer and the reserved code complete the set.

// File: rtl/cj_pkg.sv
package cj_pkg;

  typedef enum logic [2:0] {
    CJ_ALWAYS = 3'd0,
    CJ_EQ     = 3'd1,
    CJ_NE     = 3'd2,
    CJ_UGT    = 3'd3,
    CJ_UGE    = 3'd4,
    CJ_SGT    = 3'd5,
    CJ_SGE    = 3'd6,
    CJ_RSVD   = 3'd7
  } cj_cond_e;

  function automatic logic cond_is_legal(input cj_cond_e c);
    return c != CJ_RSVD;
  endfunction

endpackage

// File: rtl/cj_operand_sel.sv
module cj_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] rs2_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opb
);
  localparam int EXT_W = (DATA_W > IMM_W) ? DATA_W - IMM_W : 1;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > IMM_W) begin : g_extend
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign opb = imm_sel ? imm_ext : rs2_val;

  always_comb begin
    // R8
    imm_sign_chk: assert (!(imm_sel && DATA_W > IMM_W) || opb[DATA_W-1] == imm[IMM_W-1]);
  end
endmodule

// File: rtl/cj_cond_eval.sv
module cj_cond_eval
  import cj_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cj_cond_e          cond,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              taken,
  output logic              illegal
);
  // Unsigned a > b from the borrow of a widened subtraction.
  function automatic logic u_gt(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W:0] d;
    d = {1'b0, b} - {1'b0, a};
    return d[DATA_W];
  endfunction

  // Signed a > b: flip the sign bits, then compare as unsigned.
  function automatic logic s_gt(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] ab;
    logic [DATA_W-1:0] bb;
    ab = a ^ {1'b1, {(DATA_W-1){1'b0}}};
    bb = b ^ {1'b1, {(DATA_W-1){1'b0}}};
    return u_gt(ab, bb);
  endfunction

  logic eq_w, ugt_w, sgt_w, uge_w, sge_w;

  assign eq_w  = (opa == opb);
  assign ugt_w = u_gt(opa, opb);
  assign sgt_w = s_gt(opa, opb);
  assign uge_w = ugt_w | eq_w;
  assign sge_w = sgt_w | eq_w;

  always_comb begin
    unique case (cond)
      CJ_ALWAYS: taken = 1'b1;
      CJ_EQ:     taken = eq_w;
      CJ_NE:     taken = !eq_w;
      CJ_UGT:    taken = ugt_w;
      CJ_UGE:    taken = uge_w;
      CJ_SGT:    taken = sgt_w;
      CJ_SGE:    taken = sge_w;
      default:   taken = 1'b0;
    endcase
    illegal = !cond_is_legal(cond);
  end

  always_comb begin
    // R7
    rsvd_excl_chk: assert ($onehot0({taken, illegal}));
    // R5
    ugt_not_eq_chk: assert (!(ugt_w && eq_w));
    // R6
    sgt_not_eq_chk: assert (!(sgt_w && eq_w));
  end
endmodule

// File: rtl/cj_next_ip.sv
module cj_next_ip #(
  parameter int ADDR_W = 32
) (
  input  logic              taken,
  input  logic [ADDR_W-1:0] cur_ip,
  input  logic [ADDR_W-1:0] jump_tgt,
  output logic [ADDR_W-1:0] next_ip
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] seq_ip;

  assign seq_ip  = cur_ip + STEP;
  assign next_ip = taken ? jump_tgt : seq_ip;

  always_comb begin
    // R10
    seq_step_chk: assert (seq_ip - cur_ip == STEP);
  end
endmodule

// File: rtl/cj_branch_unit.sv
module cj_branch_unit
  import cj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        cond,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] rs1_val,
  input  logic [DATA_W-1:0] rs2_val,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [ADDR_W-1:0] cur_ip,
  input  logic [ADDR_W-1:0] jump_tgt,
  output logic              out_valid,
  output logic              taken,
  output logic              illegal,
  output logic [ADDR_W-1:0] next_ip
);
  logic [DATA_W-1:0] opb_w;
  logic              taken_w;
  logic              illegal_w;
  logic [ADDR_W-1:0] next_ip_w;

  cj_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .imm_sel (imm_sel),
    .rs2_val (rs2_val),
    .imm     (imm16),
    .opb     (opb_w)
  );

  cj_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .cond    (cj_cond_e'(cond)),
    .opa     (rs1_val),
    .opb     (opb_w),
    .taken   (taken_w),
    .illegal (illegal_w)
  );

  cj_next_ip #(.ADDR_W(ADDR_W)) u_nip (
    .taken    (taken_w),
    .cur_ip   (cur_ip),
    .jump_tgt (jump_tgt),
    .next_ip  (next_ip_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      next_ip   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken   <= taken_w;
        illegal <= illegal_w;
        next_ip <= next_ip_w;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(taken) && $stable(next_ip)));
  // R3
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd0) |=> taken);
  // R7
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd7) |=> (illegal && !taken));
  // R10
  seq_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd7) |=> next_ip == $past(cur_ip) + ADDR_W'(1));
endmodule

// File: tb/cj_branch_unit_tb.sv
module cj_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  cond = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] rs1_val = '0, rs2_val = '0, cur_ip = '0, jump_tgt = '0;
  logic [15:0] imm16 = '0;
  logic        out_valid, taken, illegal;
  logic [31:0] next_ip;

  int errors = 0;
  int checks = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cj_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond), .imm_sel(imm_sel),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .imm16(imm16), .cur_ip(cur_ip),
    .jump_tgt(jump_tgt), .out_valid(out_valid), .taken(taken), .illegal(illegal),
    .next_ip(next_ip)
  );

  // Reference model written from the requirements.
  function automatic logic [33:0] model(input logic [2:0] c, input logic isel,
      input logic [31:0] a, input logic [31:0] r2, input logic [15:0] im,
      input logic [31:0] ip, input logic [31:0] tg);
    logic [31:0] b;
    logic [32:0] diff;
    logic t, bad;
    b = isel ? 32'($signed(im)) : r2;
    diff = {1'b0, a} - {1'b0, b};
    bad = 1'b0;
    case (c)
      3'd0: t = 1'b1;
      3'd1: t = (diff == 33'd0);
      3'd2: t = (diff != 33'd0);
      3'd3: t = !diff[32] && diff != 33'd0;
      3'd4: t = !diff[32];
      3'd5: t = $signed(a) > $signed(b);
      3'd6: t = $signed(a) >= $signed(b);
      default: begin t = 1'b0; bad = 1'b1; end
    endcase
    return {t, bad, t ? tg : ip + 32'd1};
  endfunction

  task automatic drive(input string tag, input logic [2:0] c, input logic isel,
      input logic [31:0] a, input logic [31:0] r2, input logic [15:0] im,
      input logic [31:0] ip, input logic [31:0] tg);
    @(negedge clk);
    in_valid = 1'b1; cond = c; imm_sel = isel; rs1_val = a; rs2_val = r2;
    imm16 = im; cur_ip = ip; jump_tgt = tg;
    exp_q.push_back(model(c, isel, a, r2, im, ip, tg));
    tag_q.push_back(tag);
    pushed++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got taken=%0b illegal=%0b next_ip=%h, expected taken=%0b illegal=%0b next_ip=%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // Monitor: samples 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected out_valid", {taken, illegal, next_ip}, 34'h3_FFFF_FFFF);
        end else begin
          string t;
          logic [33:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          popped++;
          check(t, {taken, illegal, next_ip}, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #23;
    check("R1 reset held", {out_valid, taken, illegal, next_ip[30:0]}, 34'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {out_valid, taken, illegal, next_ip[30:0]}, 34'd0);

    drive("R3 always reg", 3'd0, 1'b0, 32'd1, 32'd2, 16'h0, 32'h100, 32'h2000);
    drive("R3 always imm", 3'd0, 1'b1, 32'h8000_0000, 32'd0, 16'h7FFF, 32'h101, 32'h3000);
    drive("R4 eq taken", 3'd1, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 32'h10, 32'h40);
    drive("R4 eq not", 3'd1, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 16'h0, 32'h10, 32'h40);
    drive("R4 ne taken", 3'd2, 1'b0, 32'd5, 32'd6, 16'h0, 32'h20, 32'h80);
    drive("R4 ne not", 3'd2, 1'b0, 32'd7, 32'd7, 16'h0, 32'h20, 32'h80);
    drive("R5 ugt topbit", 3'd3, 1'b0, 32'h8000_0000, 32'd1, 16'h0, 32'h30, 32'h90);
    drive("R5 ugt equal", 3'd3, 1'b0, 32'd9, 32'd9, 16'h0, 32'h30, 32'h90);
    drive("R5 uge equal", 3'd4, 1'b0, 32'd9, 32'd9, 16'h0, 32'h31, 32'h91);
    drive("R5 uge less", 3'd4, 1'b0, 32'd8, 32'd9, 16'h0, 32'h31, 32'h91);
    drive("R6 sgt topbit", 3'd5, 1'b0, 32'h8000_0000, 32'd1, 16'h0, 32'h40, 32'hA0);
    drive("R6 sgt equal", 3'd5, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 16'h0, 32'h40, 32'hA0);
    drive("R6 sge equal", 3'd6, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 16'h0, 32'h41, 32'hA1);
    drive("R6 sge neg", 3'd6, 1'b0, 32'hFFFF_FFFF, 32'd0, 16'h0, 32'h41, 32'hA1);
    drive("R6 sgt pos", 3'd5, 1'b0, 32'd1, 32'hFFFF_FFFF, 16'h0, 32'h42, 32'hA2);
    drive("R7 reserved", 3'd7, 1'b0, 32'd3, 32'd3, 16'h0, 32'h50, 32'hB0);
    drive("R7 reserved imm", 3'd7, 1'b1, 32'd0, 32'd0, 16'h0, 32'h51, 32'hB1);
    drive("R8 sext ffff", 3'd1, 1'b1, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 32'h60, 32'hC0);
    drive("R8 sext 8000", 3'd1, 1'b1, 32'hFFFF_8000, 32'hFFFF_8000, 16'h8000, 32'h61, 32'hC1);
    drive("R8 rs2 ignored", 3'd1, 1'b1, 32'hFFFF_8000, 32'h1234_5678, 16'h8000, 32'h61, 32'hC1);
    drive("R8 no zext", 3'd1, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 16'hFFFF, 32'h62, 32'hC2);
    drive("R8 ugt imm", 3'd3, 1'b1, 32'd5, 32'd0, 16'hFFFF, 32'h63, 32'hC3);
    drive("R8 sgt imm", 3'd5, 1'b1, 32'd5, 32'hFFFF_FFFF, 16'hFFFF, 32'h64, 32'hC4);
    drive("R9 imm ignored a", 3'd1, 1'b0, 32'd3, 32'd3, 16'h0003, 32'h70, 32'hD0);
    drive("R9 imm ignored b", 3'd1, 1'b0, 32'd3, 32'd3, 16'hFFFF, 32'h70, 32'hD0);
    drive("R9 low bits ignored", 3'd2, 1'b0, 32'd4, 32'd4, 16'h0004, 32'h71, 32'hD1);
    drive("R10 wrap", 3'd1, 1'b0, 32'd1, 32'd2, 16'h0, 32'hFFFF_FFFF, 32'hE0);
    drive("R10 taken target", 3'd4, 1'b0, 32'd2, 32'd1, 16'h0, 32'hFFFF_FFFF, 32'h1234);
    idle();
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R2 idle low", {33'd0, out_valid}, 34'd0);
    check("R2 hold", {taken, illegal, next_ip}, {1'b1, 1'b0, 32'h1234});

    for (int c = 0; c < 8; c++) begin
      drive("R2 sweep a", 3'(c), 1'b0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h200 + 32'(c), 32'h900);
      drive("R2 sweep b", 3'(c), 1'b1, 32'hFFFF_FFF0, 32'd0, 16'h000F, 32'h300 + 32'(c), 32'hA00);
    end
    idle();
    repeat (3) @(negedge clk);
    check("R2 all results seen", 34'(popped), 34'(pushed));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule